// File: doc/BRIEF.md
# Index Prefix Register-Select Remapper

This block sits between the opcode decoder of an 8-bit processor and its register file. It watches the stream of fetched opcode bytes and remembers whether the instruction now in progress was preceded by one of two index prefix bytes. While a prefix is in force, the register-select codes that would name the high byte, the low byte or the 16-bit pair of HL are steered instead to the high half, the low half or the whole of one of two 16-bit index registers. All other select codes go through unaltered.

The decoder presents the raw 3-bit operand fields and the raw 2-bit pair field of the current instruction. It receives widened select codes that the register file decodes directly. The prefix state changes only on a cycle with the fetch strobe high, so the remapping stays fixed for the whole of a multi-cycle instruction. It is released at the next fetch.

Top module: `idx_remap`

## Requirements
- R1: After reset no prefix is in force: `prefixActive` is 0, each 4-bit operand output equals `{1'b0, field}` and `pairOut` equals `{1'b0, pairIn}`.
- R2: After a fetch of 0xDD followed by a fetch of a non-prefix byte, an operand field of 100 (H) maps to 4'b1000 (first index register, high half) and a field of 101 (L) maps to 4'b1001 (first index register, low half).
- R3: After a fetch of 0xFD followed by a fetch of a non-prefix byte, a field of 100 maps to 4'b1010 (second index register, high half) and a field of 101 maps to 4'b1011 (second index register, low half).
- R4: With a prefix in force, a pair field of 10 (HL) maps to 3'b100 for 0xDD and 3'b101 for 0xFD; pair fields 00 (BC), 01 (DE) and 11 (SP) map to `{1'b0, pairIn}`.
- R5: Operand fields 000, 001, 010, 011 and 111 (B, C, D, E, A) always map to `{1'b0, field}`, prefix or not.
- R6: `prefixActive` is 0 in the cycle after a prefix byte is fetched, rises in the cycle after the next non-prefix fetch, and falls in the cycle after the fetch that follows.
- R7: When several prefix bytes are fetched in a row, the last of them alone chooses the index register.
- R8: When any operand field holds 110 (memory through HL), no operand field is remapped in that cycle: H and L fields map to `{1'b0, field}`; the pair mapping is unaffected.
- R9: A byte presented while `fetchValid` is 0 changes no state, even if it equals a prefix value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| fetchValid | input | 1 | High in a cycle where `fetchByte` is an opcode fetch |
| fetchByte | input | 8 | Fetched opcode byte |
| sel8In | input | 6 | Two raw 3-bit operand fields, field k at bits [3k+2:3k] |
| pairIn | input | 2 | Raw 16-bit pair field |
| sel8Out | output | 8 | Two widened operand selects, select k at bits [4k+3:4k] |
| pairOut | output | 3 | Widened pair select |
| prefixActive | output | 1 | A prefix applies to the instruction in progress |

## Verification
Two functions can meet in one cycle: the H/L operand remap and the memory-operand suppression, when one field names H or L and the other names 110 while a prefix is in force. The bench provokes this both in directed table rows and in the exhaustive sweep over every pair of operand fields for each prefix kind. It judges the result by expecting the H or L field to stay unmapped while the pair select is still redirected. A second meeting, a prefix fetch landing just after a non-prefix fetch, is judged by the flag timing of R6 and by which index register a chain of prefixes leaves chosen.

// File: rtl/idx_remap_pkg.sv
package idx_remap_pkg;

  // Which index register the held prefix selects.
  typedef enum logic [1:0] {
    IDX_NONE = 2'd0,
    IDX_X    = 2'd1,
    IDX_Y    = 2'd2
  } idxSel_e;

  // Strobes from the prefix tracker to the remapping datapath.
  typedef struct packed {
    logic active;
    logic useIy;
  } ctrlStrobes_t;

  localparam int SEL8W  = 3;
  localparam int SEL16W = 2;
  localparam int OUT8W  = SEL8W + 1;
  localparam int OUT16W = SEL16W + 1;

  localparam logic [SEL8W-1:0]  CODE_HIGH = 3'd4;
  localparam logic [SEL8W-1:0]  CODE_LOW  = 3'd5;
  localparam logic [SEL8W-1:0]  CODE_MEM  = 3'd6;
  localparam logic [SEL16W-1:0] PAIR_HL   = 2'd2;

endpackage

// File: rtl/idx_remap_ctrl.sv
module idx_remap_ctrl
  import idx_remap_pkg::*;
#(
  parameter int             OPW   = 8,
  parameter logic [OPW-1:0] PFX_X = 8'hDD,
  parameter logic [OPW-1:0] PFX_Y = 8'hFD
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           fetchValid,
  input  logic [OPW-1:0] fetchByte,
  output ctrlStrobes_t   strobes
);

  idxSel_e pendQ;
  idxSel_e actQ;
  logic    hitX;
  logic    hitY;

  assign hitX = (fetchByte == PFX_X);
  assign hitY = (fetchByte == PFX_Y);

  // A prefix byte only arms the pending slot; the following non-prefix
  // fetch moves it into the active slot for the whole instruction.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= IDX_NONE;
      actQ  <= IDX_NONE;
    end else if (fetchValid) begin
      if (hitX) begin
        pendQ <= IDX_X;
        actQ  <= IDX_NONE;
      end else if (hitY) begin
        pendQ <= IDX_Y;
        actQ  <= IDX_NONE;
      end else begin
        actQ  <= pendQ;
        pendQ <= IDX_NONE;
      end
    end
  end

  assign strobes.active = (actQ != IDX_NONE);
  assign strobes.useIy  = (actQ == IDX_Y);

  AST_PREFIX_BYTE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && (hitX || hitY) |=> !strobes.active); // R6

  AST_LAST_PREFIX_WINS: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && hitY |=> pendQ == IDX_Y); // R7

  AST_NO_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |=> $stable(actQ) && $stable(pendQ)); // R9

  AST_RELEASE_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && !hitX && !hitY && pendQ == IDX_NONE |=> !strobes.active); // R6

endmodule

// File: rtl/idx_remap_dp.sv
module idx_remap_dp
  import idx_remap_pkg::*;
#(
  parameter int NUM8 = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strobes,
  input  logic [NUM8*SEL8W-1:0]  sel8In,
  input  logic [SEL16W-1:0]      pairIn,
  output logic [NUM8*OUT8W-1:0]  sel8Out,
  output logic [OUT16W-1:0]      pairOut
);

  logic [NUM8-1:0] isMem;
  logic            memUsed;

  for (genvar g = 0; g < NUM8; g++) begin : gMemScan
    assign isMem[g] = (sel8In[g*SEL8W +: SEL8W] == CODE_MEM);
  end

  assign memUsed = |isMem;

  for (genvar g = 0; g < NUM8; g++) begin : gField
    logic [SEL8W-1:0] code;
    logic             isHalf;
    logic [OUT8W-1:0] mapped;

    assign code   = sel8In[g*SEL8W +: SEL8W];
    assign isHalf = (code == CODE_HIGH) || (code == CODE_LOW);

    always_comb begin
      mapped = {1'b0, code};
      if (strobes.active && !memUsed && isHalf) begin
        mapped = {1'b1, 1'b0, strobes.useIy, code == CODE_LOW};
      end
    end

    assign sel8Out[g*OUT8W +: OUT8W] = mapped;

    AST_IDLE_PLAIN: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.active |-> !sel8Out[g*OUT8W + OUT8W - 1]); // R1

    AST_MEM_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
      memUsed |-> !sel8Out[g*OUT8W + OUT8W - 1]); // R8

    AST_OTHERS_KEEP: assert property (@(posedge clk) disable iff (!rstN)
      !isHalf |-> sel8Out[g*OUT8W +: OUT8W] == {1'b0, sel8In[g*SEL8W +: SEL8W]}); // R5
  end

  always_comb begin
    pairOut = {1'b0, pairIn};
    if (strobes.active && pairIn == PAIR_HL) begin
      pairOut = {1'b1, 1'b0, strobes.useIy};
    end
  end

  AST_PAIR_HL: assert property (@(posedge clk) disable iff (!rstN)
    strobes.active && pairIn == PAIR_HL |-> pairOut[OUT16W-1]); // R4

  AST_PAIR_OTHERS: assert property (@(posedge clk) disable iff (!rstN)
    pairIn != PAIR_HL |-> !pairOut[OUT16W-1]); // R4

endmodule

// File: rtl/idx_remap.sv
module idx_remap
  import idx_remap_pkg::*;
#(
  parameter int             OPW   = 8,
  parameter int             NUM8  = 2,
  parameter logic [OPW-1:0] PFX_X = 8'hDD,
  parameter logic [OPW-1:0] PFX_Y = 8'hFD
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  fetchValid,
  input  logic [OPW-1:0]        fetchByte,
  input  logic [NUM8*3-1:0]     sel8In,
  input  logic [1:0]            pairIn,
  output logic [NUM8*4-1:0]     sel8Out,
  output logic [2:0]            pairOut,
  output logic                  prefixActive
);

  ctrlStrobes_t strobes;

  idx_remap_ctrl #(
    .OPW   (OPW),
    .PFX_X (PFX_X),
    .PFX_Y (PFX_Y)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fetchValid (fetchValid),
    .fetchByte  (fetchByte),
    .strobes    (strobes)
  );

  idx_remap_dp #(
    .NUM8 (NUM8)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .sel8In  (sel8In),
    .pairIn  (pairIn),
    .sel8Out (sel8Out),
    .pairOut (pairOut)
  );

  assign prefixActive = strobes.active;

endmodule

// File: tb/idx_remap_tb.sv
module idx_remap_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fetchValid = 1'b0;
  logic [7:0] fetchByte = 8'h00;
  logic [5:0] sel8In = 6'd0;
  logic [1:0] pairIn = 2'd0;
  logic [7:0] sel8Out;
  logic [2:0] pairOut;
  logic       prefixActive;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  idx_remap u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .fetchValid   (fetchValid),
    .fetchByte    (fetchByte),
    .sel8In       (sel8In),
    .pairIn       (pairIn),
    .sel8Out      (sel8Out),
    .pairOut      (pairOut),
    .prefixActive (prefixActive)
  );

  // pre: 0 none, 1 DD, 2 FD, 3 DD then FD, 4 FD then DD
  typedef struct packed {
    logic [2:0] pre;
    logic [2:0] s0;
    logic [2:0] s1;
    logic [1:0] pr;
    logic [3:0] e0;
    logic [3:0] e1;
    logic [2:0] ep;
    logic       ea;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 3'd4, 3'd7, 2'd2, 4'h4, 4'h7, 3'd2, 1'b0},
    '{3'd1, 3'd4, 3'd7, 2'd2, 4'h8, 4'h7, 3'd4, 1'b1},
    '{3'd2, 3'd0, 3'd5, 2'd2, 4'h0, 4'hB, 3'd5, 1'b1},
    '{3'd2, 3'd4, 3'd5, 2'd0, 4'hA, 4'hB, 3'd0, 1'b1},
    '{3'd1, 3'd5, 3'd4, 2'd3, 4'h9, 4'h8, 3'd3, 1'b1},
    '{3'd1, 3'd4, 3'd6, 2'd2, 4'h4, 4'h6, 3'd4, 1'b1},
    '{3'd2, 3'd6, 3'd5, 2'd1, 4'h6, 4'h5, 3'd1, 1'b1},
    '{3'd3, 3'd4, 3'd1, 2'd2, 4'hA, 4'h1, 3'd5, 1'b1},
    '{3'd4, 3'd5, 3'd3, 2'd2, 4'h9, 4'h3, 3'd4, 1'b1},
    '{3'd0, 3'd5, 3'd6, 2'd0, 4'h5, 4'h6, 3'd0, 1'b0},
    '{3'd1, 3'd7, 3'd0, 2'd1, 4'h7, 4'h0, 3'd1, 1'b1},
    '{3'd2, 3'd2, 3'd3, 2'd2, 4'h2, 4'h3, 3'd5, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fetch(input logic [7:0] b);
    @(negedge clk);
    fetchValid = 1'b1;
    fetchByte  = b;
    @(negedge clk);
    fetchValid = 1'b0;
    fetchByte  = 8'h00;
  endtask

  task automatic sendPrefix(input logic [2:0] pre);
    case (pre)
      3'd1: fetch(8'hDD);
      3'd2: fetch(8'hFD);
      3'd3: begin fetch(8'hDD); fetch(8'hFD); end
      3'd4: begin fetch(8'hFD); fetch(8'hDD); end
      default: ;
    endcase
  endtask

  // Independent model: kind 0 none, 1 first index, 2 second index.
  function automatic logic [3:0] model8(input int kind, input logic [2:0] c,
                                        input logic mem);
    if (kind == 0 || mem || (c != 3'd4 && c != 3'd5)) return {1'b0, c};
    return {2'b10, kind == 2, c == 3'd5};
  endfunction

  function automatic logic [2:0] modelPair(input int kind, input logic [1:0] p);
    if (kind == 0 || p != 2'd2) return {1'b0, p};
    return {2'b10, kind == 2};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    sel8In = {3'd5, 3'd4};
    pairIn = 2'd2;
    #1;
    check("R1 flag in reset", prefixActive, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check("R1 flag", prefixActive, 0);
    check("R1 sel8", sel8Out, 8'h54);
    check("R1 pair", pairOut, 3'd2);

    // Table walk (R2 R3 R4 R5 R7 R8)
    for (int i = 0; i < NVEC; i++) begin
      sendPrefix(VECS[i].pre);
      fetch(8'h40);
      sel8In = {VECS[i].s1, VECS[i].s0};
      pairIn = VECS[i].pr;
      #1;
      check("R2/R3/R7 table flag", prefixActive, VECS[i].ea);
      check("R2 R3 R5 R8 table op0", sel8Out[3:0], VECS[i].e0);
      check("R2 R3 R5 R8 table op1", sel8Out[7:4], VECS[i].e1);
      check("R4 table pair", pairOut, VECS[i].ep);
    end

    // R6 flag timing around prefix, opcode and next fetch
    fetch(8'hDD); #1;
    check("R6 idle on prefix byte", prefixActive, 0);
    fetch(8'h26); #1;
    check("R6 active after opcode", prefixActive, 1);
    // R9 ignored bytes while no strobe; flag must hold for the instruction
    @(negedge clk);
    fetchByte = 8'hFD;
    repeat (3) @(negedge clk);
    fetchByte = 8'h00;
    sel8In = {3'd0, 3'd4};
    #1;
    check("R9 hold active", prefixActive, 1);
    check("R9 still first index", sel8Out[3:0], 4'h8);
    fetch(8'h00); #1;
    check("R6 release at next fetch", prefixActive, 0);
    check("R6 plain after release", sel8Out[3:0], 4'h4);

    // R9 prefix value without strobe does not arm
    @(negedge clk);
    fetchByte = 8'hDD;
    @(negedge clk);
    fetchByte = 8'h00;
    fetch(8'h44); #1;
    check("R9 unstrobed prefix ignored", prefixActive, 0);

    // R7 three prefixes in a row
    fetch(8'hFD); fetch(8'hFD); fetch(8'hDD);
    fetch(8'h65);
    sel8In = {3'd5, 3'd4};
    pairIn = 2'd2;
    #1;
    check("R7 chain op", sel8Out, 8'h98);
    check("R7 chain pair", pairOut, 3'd4);

    // Exhaustive sweep per prefix kind
    for (int k = 0; k < 3; k++) begin
      if (k == 1) fetch(8'hDD);
      if (k == 2) fetch(8'hFD);
      fetch(8'h01);
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          for (int p = 0; p < 4; p++) begin
            logic memUse;
            sel8In = {3'(b), 3'(a)};
            pairIn = 2'(p);
            memUse = (a == 6) || (b == 6);
            #1;
            check("R2 R3 R5 R8 sweep op0", sel8Out[3:0], model8(k, 3'(a), memUse));
            check("R2 R3 R5 R8 sweep op1", sel8Out[7:4], model8(k, 3'(b), memUse));
            check("R4 sweep pair", pairOut, modelPair(k, 2'(p)));
          end
        end
      end
    end

    // R1 reset clears an active prefix
    fetch(8'hFD); fetch(8'h24);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 reset clears", prefixActive, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule